// File: doc/BRIEF.md
# Scheduled Serial Avionics Word Transmitter

This block sends 32-bit avionics data words as a bipolar return-to-zero bit stream on one channel. Words arrive from a show-ahead data queue. A second queue, kept in step with the first, holds 16-bit gap words. When scheduling is switched on, each gap word gives the number of idle bit cells that go with its data word. A mode input places those idle cells either after the word or ahead of it. When scheduling is off, words go out back to back with four idle cells between them, and the gap queue is left alone.

For test traffic, the word length can be shortened to 31 bits or stretched to 33 bits. The parity bit can be odd, even or left as the raw data bit. The bit rate is set by a half-cell divider. That divider runs freely from reset, and new words and gaps begin only on its cell boundaries. As a result, several transmitters that share a reset, a divider value and one enable signal start within the same cell.

Top module: `a429_sched_tx`

## Requirements
- R1: In scheduled mode with gapBefore low, a gap value of N places exactly N idle cells between the last bit of its word and the first bit of the next word. A value of 0 places none.
- R2: In scheduled mode with gapBefore high, a non-zero gap value N places N idle cells before its word. The gap word is popped when those idle cells begin, and the data word is popped when they end.
- R3: With schedOn low, consecutive words are separated by exactly 4 idle cells, and gapRead never pulses.
- R4: A bit cell lasts 2*halfDiv clocks (a halfDiv of 0 acts as 1). A 1 raises lineHi and a 0 raises lineLo for the first halfDiv clocks, and both lines are low for the second half of the cell and for all idle cells. lineHi and lineLo are never high together.
- R5: Bits leave in the order dataIn[0], dataIn[1] … dataIn[30], followed by the 32nd bit.
- R6: The 32nd bit depends on parSel. With parSel 0 it makes the count of ones in the 32 bits odd. With parSel 1 it makes that count even. With parSel 2 or 3 it equals dataIn[31].
- R7: lenSel sets the word length. With 0 or 3 a word has 32 bits. With 1 the 32nd bit is dropped and 31 bits are sent. With 2 a 33rd bit of value 0 is added after the 32nd.
- R8: While txEnable is low, no word or gap is started and no queue is popped. A word already being sent still completes.
- R9: Words and gaps start only on a cell boundary. The boundaries fall every 2*halfDiv clocks, counted from the first clock after reset. An enable raised partway through a cell takes effect at the next boundary.
- R10: After reset both line outputs are low and neither queue is popped.
- R11: dataRead pulses for one clock per word sent and gapRead for one clock per gap word used. Neither pulses while its valid input is low. With gapBefore low, the two pulse in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Allows new words and gaps to start |
| halfDiv | input | 16 | Clocks per half bit cell |
| schedOn | input | 1 | Use gap words from the gap queue |
| gapBefore | input | 1 | Gap precedes its word (1) or follows it (0) |
| lenSel | input | 2 | Word length select: 0/3 = 32, 1 = 31, 2 = 33 |
| parSel | input | 2 | 32nd bit: 0 odd, 1 even, 2/3 raw dataIn[31] |
| dataValid | input | 1 | Data queue head is valid |
| dataIn | input | 32 | Data queue head word |
| dataRead | output | 1 | Pop data queue |
| gapValid | input | 1 | Gap queue head is valid |
| gapIn | input | 16 | Gap queue head value, in bit cells |
| gapRead | output | 1 | Pop gap queue |
| lineHi | output | 1 | Positive line leg |
| lineLo | output | 1 | Negative line leg |

## Verification
Two events can fall on the same cell boundary: the end of a word or gap, and the start of the next unit. That start also includes both queue pops in post-gap mode. A gap value of 0 after a word makes the next word begin in the very cell that follows, and the bench checks the cell spacing there and counts every pop on both queues, flagging any clock in which one queue pops without the other. Dropping txEnable while a word is being sent tests the enable path as that word ends, and the bench judges it by the total bit count and by the second word staying in the queue.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE_GAP,
    ST_SEND,
    ST_POST_GAP
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic shiftBit;
    logic drive;
  } dpStrobe_t;

  localparam logic [1:0] PAR_ODD  = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;

  localparam logic [1:0] LEN_SHORT = 2'd1;
  localparam logic [1:0] LEN_LONG  = 2'd2;

endpackage

// File: rtl/a429_tx_ctrl.sv
module a429_tx_ctrl
  import a429_tx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int GAP_W   = 16,
  parameter int MIN_GAP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             schedOn,
  input  logic             gapBefore,
  input  logic [1:0]       lenSel,
  input  logic             dataValid,
  output logic             dataRead,
  input  logic             gapValid,
  input  logic [GAP_W-1:0] gapIn,
  output logic             gapRead,
  output dpStrobe_t        strobe
);

  localparam int CNT_W = DIV_W + 1;
  localparam int IDX_W = 6;

  logic [DIV_W-1:0] effHalf;
  logic [CNT_W-1:0] cellLen;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             firstHalf;

  txState_t         state, nxtState;
  logic [GAP_W-1:0] gapCnt, nxtGap;
  logic [GAP_W-1:0] heldGap, nxtHeld;
  logic [GAP_W-1:0] postLen;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] wordLen;
  logic             canStart;
  logic             wantFetch;
  logic             doLoad;
  logic             popData;
  logic             popGap;

  // free-running cell timer, phase fixed by reset only
  assign effHalf   = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign cellLen   = {effHalf, 1'b0};
  assign tick      = (cnt >= cellLen - CNT_W'(1));
  assign firstHalf = (cnt < {1'b0, effHalf});

  always_ff @(posedge clk) begin
    if (!rstN)     cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    case (lenSel)
      LEN_SHORT: wordLen = IDX_W'(31);
      LEN_LONG:  wordLen = IDX_W'(33);
      default:   wordLen = IDX_W'(32);
    endcase
  end

  assign postLen  = schedOn ? (gapBefore ? '0 : heldGap) : GAP_W'(MIN_GAP);
  assign canStart = txEnable && dataValid && (!schedOn || gapValid);

  always_comb begin
    nxtState  = state;
    nxtGap    = gapCnt;
    nxtHeld   = heldGap;
    doLoad    = 1'b0;
    popData   = 1'b0;
    popGap    = 1'b0;
    wantFetch = 1'b0;
    if (tick) begin
      case (state)
        ST_IDLE: wantFetch = 1'b1;
        ST_PRE_GAP: begin
          if (gapCnt <= GAP_W'(1)) begin
            if (dataValid) begin
              nxtState = ST_SEND;
              doLoad   = 1'b1;
              popData  = 1'b1;
            end else begin
              nxtState = ST_IDLE;
            end
          end else begin
            nxtGap = gapCnt - GAP_W'(1);
          end
        end
        ST_SEND: begin
          if (bitIdx == wordLen - IDX_W'(1)) begin
            if (postLen != '0) begin
              nxtState = ST_POST_GAP;
              nxtGap   = postLen;
            end else begin
              wantFetch = 1'b1;
            end
          end
        end
        default: begin
          if (gapCnt <= GAP_W'(1)) wantFetch = 1'b1;
          else                     nxtGap = gapCnt - GAP_W'(1);
        end
      endcase
    end
    if (wantFetch) begin
      nxtState = ST_IDLE;
      if (canStart) begin
        if (schedOn && gapBefore && gapIn != '0) begin
          nxtState = ST_PRE_GAP;
          nxtGap   = gapIn;
          popGap   = 1'b1;
        end else begin
          nxtState = ST_SEND;
          doLoad   = 1'b1;
          popData  = 1'b1;
          popGap   = schedOn;
          nxtHeld  = gapIn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gapCnt  <= '0;
      heldGap <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= nxtState;
      gapCnt  <= nxtGap;
      heldGap <= nxtHeld;
      if (doLoad)                         bitIdx <= '0;
      else if (state == ST_SEND && tick)  bitIdx <= bitIdx + IDX_W'(1);
    end
  end

  assign dataRead        = popData;
  assign gapRead         = popGap;
  assign strobe.loadWord = doLoad;
  assign strobe.shiftBit = (state == ST_SEND) && tick;
  assign strobe.drive    = (state == ST_SEND) && firstHalf;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !txEnable) |=> (state == ST_IDLE)); // R8
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_SEND) |-> (cnt == '0)); // R9
  AST_GAP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST_GAP && tick && gapCnt > GAP_W'(1)) |=>
      (gapCnt == $past(gapCnt) - GAP_W'(1))); // R1
  AST_DATA_POP_VALID: assert property (@(posedge clk) disable iff (!rstN)
    dataRead |-> dataValid); // R11
  AST_GAP_POP_VALID: assert property (@(posedge clk) disable iff (!rstN)
    gapRead |-> gapValid); // R11

endmodule

// File: rtl/a429_tx_dp.sv
module a429_tx_dp
  import a429_tx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        parSel,
  input  logic [WORD_W-1:0] dataIn,
  output logic              lineHi,
  output logic              lineLo
);

  localparam int SH_W = WORD_W + 1;

  logic [SH_W-1:0] shiftReg;
  logic            lowOnes;
  logic            topBit;

  assign lowOnes = ^dataIn[WORD_W-2:0];

  always_comb begin
    case (parSel)
      PAR_ODD:  topBit = ~lowOnes;
      PAR_EVEN: topBit = lowOnes;
      default:  topBit = dataIn[WORD_W-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.loadWord) shiftReg <= {1'b0, topBit, dataIn[WORD_W-2:0]};
    else if (strobe.shiftBit) shiftReg <= {1'b0, shiftReg[SH_W-1:1]};
  end

  assign lineHi = strobe.drive &  shiftReg[0];
  assign lineLo = strobe.drive & ~shiftReg[0];

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadWord || strobe.shiftBit) |=> $stable(shiftReg)); // R5

endmodule

// File: rtl/a429_sched_tx.sv
module a429_sched_tx
  import a429_tx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int GAP_W   = 16,
  parameter int WORD_W  = 32,
  parameter int MIN_GAP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              schedOn,
  input  logic              gapBefore,
  input  logic [1:0]        lenSel,
  input  logic [1:0]        parSel,
  input  logic              dataValid,
  input  logic [WORD_W-1:0] dataIn,
  output logic              dataRead,
  input  logic              gapValid,
  input  logic [GAP_W-1:0]  gapIn,
  output logic              gapRead,
  output logic              lineHi,
  output logic              lineLo
);

  dpStrobe_t strobe;

  a429_tx_ctrl #(.DIV_W(DIV_W), .GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) uCtrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .halfDiv(halfDiv),
    .schedOn(schedOn), .gapBefore(gapBefore), .lenSel(lenSel),
    .dataValid(dataValid), .dataRead(dataRead),
    .gapValid(gapValid), .gapIn(gapIn), .gapRead(gapRead),
    .strobe(strobe)
  );

  a429_tx_dp #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .parSel(parSel),
    .dataIn(dataIn), .lineHi(lineHi), .lineLo(lineLo)
  );

endmodule

// File: tb/a429_sched_tx_test.sv
module a429_sched_tx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEnable = 1'b0;
  logic [15:0] halfDiv = 16'd2;
  logic        schedOn = 1'b0;
  logic        gapBefore = 1'b0;
  logic [1:0]  lenSel = 2'd0;
  logic [1:0]  parSel = 2'd0;
  logic        dataValid, gapValid, dataRead, gapRead, lineHi, lineLo;
  logic [31:0] dataIn;
  logic [15:0] gapIn;

  logic [31:0] dMem [0:15];
  logic [15:0] gMem [0:15];
  int dWr = 0, gWr = 0, dRd, gRd, popSkew;
  int cyc;
  int nChecks = 0, nFail = 0;
  int cellL = 4;
  bit finished = 0;

  logic bitVal [0:255];
  int   bitCyc [0:255];
  int   nBits, riseCyc, hiLenBad;
  logic prevAct, act;

  always #4 clk = ~clk;

  a429_sched_tx uut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .halfDiv(halfDiv),
    .schedOn(schedOn), .gapBefore(gapBefore), .lenSel(lenSel), .parSel(parSel),
    .dataValid(dataValid), .dataIn(dataIn), .dataRead(dataRead),
    .gapValid(gapValid), .gapIn(gapIn), .gapRead(gapRead),
    .lineHi(lineHi), .lineLo(lineLo)
  );

  assign dataValid = dRd < dWr;
  assign gapValid  = gRd < gWr;
  assign dataIn    = (dRd < 16) ? dMem[dRd] : 32'h0;
  assign gapIn     = (gRd < 16) ? gMem[gRd] : 16'h0;

  always @(posedge clk) begin
    if (!rstN) begin
      cyc <= 0; dRd <= 0; gRd <= 0; popSkew <= 0;
    end else begin
      cyc <= cyc + 1;
      if (dataRead) dRd <= dRd + 1;
      if (gapRead)  gRd <= gRd + 1;
      if (schedOn && !gapBefore && (dataRead != gapRead)) popSkew <= popSkew + 1;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      nBits = 0; prevAct = 0; hiLenBad = 0; riseCyc = 0;
    end else begin
      act = lineHi | lineLo;
      if (lineHi && lineLo) hiLenBad++;
      if (act && !prevAct) begin
        if (nBits < 256) begin
          bitVal[nBits] = lineHi;
          bitCyc[nBits] = cyc;
        end
        nBits++;
        riseCyc = cyc;
      end
      if (!act && prevAct && (cyc - riseCyc != int'(halfDiv))) hiLenBad++;
      prevAct = act;
    end
  end

  task automatic check(bit ok, string tag, longint act_v, longint exp_v);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  function automatic logic expBit(logic [31:0] w, logic [1:0] par, int i);
    if (i < 31) return w[i];
    if (i == 31) begin
      if (par == 2'd0) return ~(^w[30:0]);
      if (par == 2'd1) return ^w[30:0];
      return w[31];
    end
    return 1'b0;
  endfunction

  task automatic resetDut(int div, bit sch, bit bef, logic [1:0] len, logic [1:0] par);
    @(negedge clk);
    rstN = 0; txEnable = 0;
    halfDiv = 16'(div); cellL = 2 * div;
    schedOn = sch; gapBefore = bef; lenSel = len; parSel = par;
    dWr = 0; gWr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic pushWord(logic [31:0] w);
    dMem[dWr] = w; dWr++;
  endtask

  task automatic pushGap(logic [15:0] g);
    gMem[gWr] = g; gWr++;
  endtask

  task automatic waitBits(int n, string tag);
    int t = 0;
    while (nBits < n && t < 6000) begin
      @(negedge clk); t++;
    end
    repeat (2 * cellL) @(negedge clk);
    check(nBits >= n, tag, nBits, n);
  endtask

  task automatic checkWord(int base, logic [31:0] w, logic [1:0] par, int len, string tag);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      if (bitVal[base + i] !== expBit(w, par, i)) bad++;
      if (i > 0 && bitCyc[base + i] - bitCyc[base + i - 1] != cellL) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic enableNow(output int j);
    @(negedge clk);
    j = cyc;
    txEnable = 1;
  endtask

  // R10
  task automatic testReset();
    resetDut(2, 0, 0, 2'd0, 2'd0);
    @(negedge clk);
    check(!lineHi && !lineLo, "R10 lines null after reset", {lineHi, lineLo}, 0);
    check(!dataRead && !gapRead, "R10 no pops after reset", {dataRead, gapRead}, 0);
  endtask

  // R3 R4 R5 R6 R9
  task automatic testBackToBack();
    int j;
    resetDut(2, 0, 0, 2'd0, 2'd0);
    pushWord(32'hA5A5_1234); pushWord(32'h7FFF_0003); pushGap(16'd9);
    repeat (3) @(negedge clk);
    enableNow(j);
    waitBits(64, "R3 words sent");
    checkWord(0,  32'hA5A5_1234, 2'd0, 32, "R5 R6 word1 odd parity");
    checkWord(32, 32'h7FFF_0003, 2'd0, 32, "R5 R6 word2 odd parity");
    check(bitCyc[32] - bitCyc[31] == 5 * cellL, "R3 four idle cells",
          bitCyc[32] - bitCyc[31], 5 * cellL);
    check(gRd == 0, "R3 gap queue untouched", gRd, 0);
    check(hiLenBad == 0, "R4 half-cell drive", hiLenBad, 0);
    check(bitCyc[0] == (j / cellL + 1) * cellL, "R9 first bit on boundary",
          bitCyc[0], (j / cellL + 1) * cellL);
  endtask

  // R6
  task automatic testParity();
    resetDut(2, 0, 0, 2'd0, 2'd1);
    pushWord(32'h0000_0003); pushWord(32'h0000_0007);
    txEnable = 1;
    waitBits(64, "R6 even words sent");
    checkWord(0,  32'h0000_0003, 2'd1, 32, "R6 even parity word1");
    checkWord(32, 32'h0000_0007, 2'd1, 32, "R6 even parity word2");
    resetDut(2, 0, 0, 2'd0, 2'd2);
    pushWord(32'h8000_0001); pushWord(32'h0000_0001);
    txEnable = 1;
    waitBits(64, "R6 raw words sent");
    check(bitVal[31] == 1'b1 && bitVal[63] == 1'b0, "R6 raw bit 32",
          {bitVal[31], bitVal[63]}, 2);
  endtask

  // R7
  task automatic testLength();
    resetDut(2, 0, 0, 2'd1, 2'd0);
    pushWord(32'h1234_5678); pushWord(32'h0F0F_F0F0);
    txEnable = 1;
    waitBits(62, "R7 short words sent");
    checkWord(0,  32'h1234_5678, 2'd0, 31, "R7 31-bit word1");
    checkWord(31, 32'h0F0F_F0F0, 2'd0, 31, "R7 31-bit word2");
    check(bitCyc[31] - bitCyc[30] == 5 * cellL, "R7 31-bit boundary",
          bitCyc[31] - bitCyc[30], 5 * cellL);
    resetDut(2, 0, 0, 2'd2, 2'd0);
    pushWord(32'hFFFF_FFFF); pushWord(32'h0000_0001);
    txEnable = 1;
    waitBits(66, "R7 long words sent");
    checkWord(0,  32'hFFFF_FFFF, 2'd0, 33, "R7 33-bit word1");
    checkWord(33, 32'h0000_0001, 2'd0, 33, "R7 33-bit word2");
    check(bitCyc[33] - bitCyc[32] == 5 * cellL, "R7 33-bit boundary",
          bitCyc[33] - bitCyc[32], 5 * cellL);
  endtask

  // R1 R11
  task automatic testPostGap();
    resetDut(2, 1, 0, 2'd0, 2'd0);
    pushWord(32'h0000_00FF); pushWord(32'h1111_1111); pushWord(32'h2222_2222);
    pushGap(16'd10); pushGap(16'd0); pushGap(16'd3);
    txEnable = 1;
    waitBits(96, "R1 scheduled words sent");
    check(bitCyc[32] - bitCyc[31] == 11 * cellL, "R1 gap of ten",
          bitCyc[32] - bitCyc[31], 11 * cellL);
    check(bitCyc[64] - bitCyc[63] == cellL, "R1 gap of zero",
          bitCyc[64] - bitCyc[63], cellL);
    checkWord(64, 32'h2222_2222, 2'd0, 32, "R1 word after zero gap");
    check(dRd == 3 && gRd == 3, "R11 pop counts", dRd * 10 + gRd, 33);
    check(popSkew == 0, "R11 paired pops", popSkew, 0);
  endtask

  // R2 R9
  task automatic testPreGap();
    int j;
    resetDut(2, 1, 1, 2'd0, 2'd0);
    pushWord(32'h0000_0005); pushWord(32'h0000_0006); pushWord(32'h0000_0007);
    pushGap(16'd6); pushGap(16'd2); pushGap(16'd0);
    repeat (2) @(negedge clk);
    enableNow(j);
    waitBits(96, "R2 pre-gap words sent");
    check(bitCyc[0] == (j / cellL + 1) * cellL + 6 * cellL, "R2 R9 leading gap",
          bitCyc[0], (j / cellL + 1) * cellL + 6 * cellL);
    check(bitCyc[32] - bitCyc[31] == 3 * cellL, "R2 gap of two ahead",
          bitCyc[32] - bitCyc[31], 3 * cellL);
    check(bitCyc[64] - bitCyc[63] == cellL, "R2 zero gap ahead",
          bitCyc[64] - bitCyc[63], cellL);
    check(dRd == 3 && gRd == 3, "R2 pop counts", dRd * 10 + gRd, 33);
  endtask

  // R8 R9
  task automatic testEnable();
    int j;
    resetDut(3, 0, 0, 2'd0, 2'd0);
    pushWord(32'hC3C3_5A5A); pushWord(32'h0000_0009);
    repeat (50) @(negedge clk);
    check(nBits == 0 && dRd == 0, "R8 held while disabled", nBits + dRd, 0);
    while (cyc % cellL != 2) @(negedge clk);
    j = cyc;
    txEnable = 1;
    while (nBits < 5) @(negedge clk);
    txEnable = 0;
    repeat (400) @(negedge clk);
    check(bitCyc[0] == (j / cellL + 1) * cellL, "R9 mid-cell enable waits",
          bitCyc[0], (j / cellL + 1) * cellL);
    check(nBits == 32, "R8 word in flight completes", nBits, 32);
    check(dRd == 1, "R8 next word not started", dRd, 1);
    checkWord(0, 32'hC3C3_5A5A, 2'd0, 32, "R8 R4 word content div 3");
    check(hiLenBad == 0, "R4 half-cell drive div 3", hiLenBad, 0);
  endtask

  initial begin
    testReset();
    testBackToBack();
    testParity();
    testLength();
    testPostGap();
    testPreGap();
    testEnable();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule